// File: doc/BRIEF.md
# Peak-Hold Spectrum Display Decimator

This block turns a stream of spectral power values, one per frequency bin, into a much shorter line of display pixels. A zoom window picks which bins are shown. The window starts at a chosen bin. Each pixel covers a fixed number of consecutive bins, and that number is the zoom ratio. Every pixel reports the largest power found among its bins, so a narrow strong carrier stays visible on a coarse display instead of being averaged away or missed by sampling.

Bins arrive as valid beats that carry an index and a power value. The first beat of a frame carries a frame-start flag and the last beat carries a frame-end flag. Bin indices are expected in ascending, contiguous order within a frame, and idle cycles may appear between beats. The zoom settings are captured only on the frame-start beat, so software may rewrite them at any time without tearing a frame.

The block also maps a pixel index chosen on the display back to the first bin that pixel covers, using the zoom settings of the current frame. At full zoom (one bin per pixel) that is the exact bin of interest.

Top module: `peak_span_decimator`

## Requirements
- R1: After reset `px_valid` is 0, and the held zoom settings are start bin 0 and one bin per pixel, so `pick_bin` equals `pick_px`.
- R2: Each emitted pixel reports in `px_peak` the maximum `bin_pwr` among the bins of its group.
- R3: A bin whose index is below the start bin, or at or above start + pixel count × bins per pixel, produces no output and does not affect any pixel.
- R4: Pixel k (reported on `px_idx`) covers bins start + k×ratio through start + k×ratio + ratio − 1. Pixels are emitted in ascending order from 0, and `px_idx` stays below the pixel count.
- R5: With a ratio of 1, every in-window bin produces one pixel whose peak equals that bin's power.
- R6: A bins-per-pixel value of 0 behaves exactly as a value of 1.
- R7: A pixel is emitted (`px_valid` high for one cycle) in the cycle after the beat that carries the last bin of its group. No pixel is emitted for the other beats of a group or for idle cycles.
- R8: If a frame ends inside a group, the frame-end beat emits that partial pixel with the maximum over the bins seen so far.
- R9: The start bin, ratio and pixel count are captured only on a beat with `bin_first` set. Changes at other times take effect only at the next frame start.
- R10: `pick_bin` equals held start + `pick_px` × held ratio, modulo 2^BIN_W.
- R11: Idle cycles between beats change neither the grouping nor the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_start_bin | input | BIN_W | First bin of the zoom window |
| cfg_bins_per_px | input | RATIO_W | Bins per pixel (0 is treated as 1) |
| cfg_px_count | input | PIX_W | Number of display pixels |
| bin_valid | input | 1 | Input beat present |
| bin_first | input | 1 | Beat is the first bin of a frame |
| bin_last | input | 1 | Beat is the last bin of a frame |
| bin_idx | input | BIN_W | Bin index of the beat |
| bin_pwr | input | PWR_W | Power value of the bin |
| px_valid | output | 1 | Pixel emitted this cycle |
| px_idx | output | PIX_W | Index of the emitted pixel |
| px_peak | output | PWR_W | Peak power of the emitted pixel |
| pick_px | input | PIX_W | Display pixel to map back to a bin |
| pick_bin | output | BIN_W | First bin covered by `pick_px` |

## Verification
The hardest case to reach is a frame ending in the middle of a group, because the window normally closes on a group boundary. The bench reaches it by sweeping start bins, ratios and pixel counts over a short frame, so that several windows extend past the last bin and the final beat falls partway through a group. The sweep also rewrites the zoom inputs right after each frame-start beat and inserts idle cycles in alternate frames. Every later result and the pixel-to-bin mapping must therefore come from the captured settings, not from the live inputs.

// File: rtl/psd_pkg.sv
// Package: shared types for the peak-hold spectrum decimator.
// Assumes nothing beyond standard SystemVerilog.
package psd_pkg;

    // Classification of one input beat with respect to the open pixel group.
    typedef enum logic [1:0] {
        BEAT_SKIP  = 2'd0,   // outside window, nothing pending to flush
        BEAT_ACCUM = 2'd1,   // inside window, group still open
        BEAT_CLOSE = 2'd2,   // inside window, closes the group
        BEAT_FLUSH = 2'd3    // frame ends with a partial group pending
    } beat_kind_e;

endpackage

// File: rtl/psd_zoom_regs.sv
// Module: psd_zoom_regs
// Holds the zoom settings of the current frame. Captures start bin, ratio
// (0 clamped to 1) and pixel count on a frame-start beat and derives the
// window span. The "eff" outputs give the settings that apply to the
// current beat: the new ones on a capture beat, the held ones otherwise.
// Assumes capture is asserted only on a valid frame-start beat.
module psd_zoom_regs #(
    parameter int BIN_W   = 12,
    parameter int PIX_W   = 10,
    parameter int RATIO_W = 6,
    parameter int SPAN_W  = PIX_W + RATIO_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture,
    input  logic [BIN_W-1:0]   cfg_start,
    input  logic [RATIO_W-1:0] cfg_ratio,
    input  logic [PIX_W-1:0]   cfg_pixels,
    output logic [BIN_W-1:0]   eff_start,
    output logic [RATIO_W-1:0] eff_ratio,
    output logic [SPAN_W-1:0]  eff_span,
    output logic [BIN_W-1:0]   held_start,
    output logic [RATIO_W-1:0] held_ratio,
    output logic [PIX_W-1:0]   held_pixels
);

    logic [RATIO_W-1:0] ratio_fix;
    logic [SPAN_W-1:0]  span_new;
    logic [SPAN_W-1:0]  held_span;

    // Clamp a zero ratio to one and compute the window span in bins.
    always_comb begin
        ratio_fix = (cfg_ratio == '0) ? RATIO_W'(1) : cfg_ratio;
        span_new  = SPAN_W'(cfg_pixels) * SPAN_W'(ratio_fix);
    end

    // Select the settings that govern the present beat.
    always_comb begin
        eff_start = capture ? cfg_start : held_start;
        eff_ratio = capture ? ratio_fix : held_ratio;
        eff_span  = capture ? span_new  : held_span;
    end

    // Capture the settings at frame start only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_start  <= '0;
            held_ratio  <= RATIO_W'(1);
            held_pixels <= '0;
            held_span   <= '0;
        end else if (capture) begin
            held_start  <= cfg_start;
            held_ratio  <= ratio_fix;
            held_pixels <= cfg_pixels;
            held_span   <= span_new;
        end
    end

    // Held settings move only on a capture beat.
    assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> ($stable(held_start) && $stable(held_ratio) && $stable(held_pixels)));

endmodule

// File: rtl/psd_window_gate.sv
// Module: psd_window_gate
// Decides whether a bin index falls inside the zoom window
// [start, start + span). Purely combinational.
// Assumes span already reflects the clamped ratio.
module psd_window_gate #(
    parameter int BIN_W  = 12,
    parameter int SPAN_W = 16
) (
    input  logic [BIN_W-1:0]  bin,
    input  logic [BIN_W-1:0]  start,
    input  logic [SPAN_W-1:0] span,
    output logic              in_win
);

    localparam int CMP_W = ((BIN_W > SPAN_W) ? BIN_W : SPAN_W) + 1;

    logic [BIN_W-1:0] offset;

    // Offset from the window start, compared against the span in a wide field.
    always_comb begin
        offset = bin - start;
        in_win = (bin >= start) && (CMP_W'(offset) < CMP_W'(span));
    end

endmodule

// File: rtl/psd_group_peak.sv
// Module: psd_group_peak
// Tracks the open pixel group: bins counted, running maximum and pixel
// index. Emits a registered pixel when a group closes or when the frame
// ends with a partial group pending. A frame-start beat clears the state.
// Assumes in-window bins arrive in ascending contiguous order.
module psd_group_peak
    import psd_pkg::*;
#(
    parameter int PIX_W   = 10,
    parameter int RATIO_W = 6,
    parameter int PWR_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               beat_valid,
    input  logic               beat_sof,
    input  logic               beat_eof,
    input  logic               in_win,
    input  logic [PWR_W-1:0]   pwr,
    input  logic [RATIO_W-1:0] ratio,
    output logic               out_valid,
    output logic [PIX_W-1:0]   out_pix,
    output logic [PWR_W-1:0]   out_pwr
);

    logic               sof_hit;
    logic [PIX_W-1:0]   pix_q, pix_d, base_pix;
    logic [RATIO_W-1:0] cnt_q, cnt_d, base_cnt;
    logic               pend_q, pend_d, base_pend;
    logic [PWR_W-1:0]   max_q, max_d, merged;
    logic               emit_d;
    logic [PIX_W-1:0]   emit_pix;
    logic [PWR_W-1:0]   emit_pwr;
    beat_kind_e         kind;

    // Starting point for this beat: cleared on a frame start.
    always_comb begin
        sof_hit   = beat_valid && beat_sof;
        base_pix  = sof_hit ? '0 : pix_q;
        base_cnt  = sof_hit ? '0 : cnt_q;
        base_pend = sof_hit ? 1'b0 : pend_q;
        merged    = (base_pend && (max_q > pwr)) ? max_q : pwr;
    end

    // Classify the beat against the open group.
    always_comb begin
        kind = BEAT_SKIP;
        if (beat_valid) begin
            if (in_win) begin
                kind = ((base_cnt == ratio - RATIO_W'(1)) || beat_eof) ? BEAT_CLOSE : BEAT_ACCUM;
            end else if (beat_eof && base_pend) begin
                kind = BEAT_FLUSH;
            end
        end
    end

    // Next-state and emission values for each beat kind.
    always_comb begin
        pix_d    = beat_valid ? base_pix  : pix_q;
        cnt_d    = beat_valid ? base_cnt  : cnt_q;
        pend_d   = beat_valid ? base_pend : pend_q;
        max_d    = max_q;
        emit_d   = 1'b0;
        emit_pix = out_pix;
        emit_pwr = out_pwr;
        case (kind)
            BEAT_ACCUM: begin
                cnt_d  = base_cnt + RATIO_W'(1);
                pend_d = 1'b1;
                max_d  = merged;
            end
            BEAT_CLOSE: begin
                emit_d   = 1'b1;
                emit_pix = base_pix;
                emit_pwr = merged;
                pix_d    = base_pix + PIX_W'(1);
                cnt_d    = '0;
                pend_d   = 1'b0;
            end
            BEAT_FLUSH: begin
                emit_d   = 1'b1;
                emit_pix = base_pix;
                emit_pwr = max_q;
                pix_d    = base_pix + PIX_W'(1);
                cnt_d    = '0;
                pend_d   = 1'b0;
            end
            default: ;
        endcase
    end

    // Group state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_q  <= '0;
            cnt_q  <= '0;
            pend_q <= 1'b0;
            max_q  <= '0;
        end else begin
            pix_q  <= pix_d;
            cnt_q  <= cnt_d;
            pend_q <= pend_d;
            max_q  <= max_d;
        end
    end

    // Registered pixel output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
            out_pwr   <= '0;
        end else begin
            out_valid <= emit_d;
            out_pix   <= emit_pix;
            out_pwr   <= emit_pwr;
        end
    end

    // A pixel appears only in the cycle after an input beat.
    assert_emit_after_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(beat_valid));

    // The open group never holds a full ratio of bins.
    assert_count_below_ratio_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sof_hit |-> (cnt_q < ratio));

endmodule

// File: rtl/psd_pixel_locator.sv
// Module: psd_pixel_locator
// Maps a display pixel index back to the first bin it covers, using the
// held zoom settings. Combinational; the result wraps modulo 2^BIN_W.
module psd_pixel_locator #(
    parameter int BIN_W   = 12,
    parameter int PIX_W   = 10,
    parameter int RATIO_W = 6
) (
    input  logic [BIN_W-1:0]   start,
    input  logic [RATIO_W-1:0] ratio,
    input  logic [PIX_W-1:0]   pix,
    output logic [BIN_W-1:0]   bin
);

    // First bin of the pixel: start plus pixel times ratio.
    always_comb begin
        bin = start + BIN_W'(pix) * BIN_W'(ratio);
    end

endmodule

// File: rtl/peak_span_decimator.sv
// Module: peak_span_decimator (top)
// Reduces a bin-indexed power stream to a pixel line. Each pixel reports
// the peak of a group of consecutive bins inside a zoom window. Also maps
// a chosen pixel back to its first bin.
// Assumes ascending contiguous bin indices within a frame, frame start on
// the first beat and frame end on the last.
module peak_span_decimator #(
    parameter int BIN_W   = 12,
    parameter int PIX_W   = 10,
    parameter int RATIO_W = 6,
    parameter int PWR_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BIN_W-1:0]   cfg_start_bin,
    input  logic [RATIO_W-1:0] cfg_bins_per_px,
    input  logic [PIX_W-1:0]   cfg_px_count,
    input  logic               bin_valid,
    input  logic               bin_first,
    input  logic               bin_last,
    input  logic [BIN_W-1:0]   bin_idx,
    input  logic [PWR_W-1:0]   bin_pwr,
    output logic               px_valid,
    output logic [PIX_W-1:0]   px_idx,
    output logic [PWR_W-1:0]   px_peak,
    input  logic [PIX_W-1:0]   pick_px,
    output logic [BIN_W-1:0]   pick_bin
);

    localparam int SPAN_W = PIX_W + RATIO_W;

    logic               capture;
    logic [BIN_W-1:0]   eff_start, held_start;
    logic [RATIO_W-1:0] eff_ratio, held_ratio;
    logic [SPAN_W-1:0]  eff_span;
    logic [PIX_W-1:0]   held_pixels;
    logic               in_win;

    // Settings are captured on a valid frame-start beat.
    always_comb begin
        capture = bin_valid && bin_first;
    end

    psd_zoom_regs #(
        .BIN_W(BIN_W), .PIX_W(PIX_W), .RATIO_W(RATIO_W), .SPAN_W(SPAN_W)
    ) u_zoom (
        .clk(clk), .rst_n(rst_n), .capture(capture),
        .cfg_start(cfg_start_bin), .cfg_ratio(cfg_bins_per_px), .cfg_pixels(cfg_px_count),
        .eff_start(eff_start), .eff_ratio(eff_ratio), .eff_span(eff_span),
        .held_start(held_start), .held_ratio(held_ratio), .held_pixels(held_pixels)
    );

    psd_window_gate #(
        .BIN_W(BIN_W), .SPAN_W(SPAN_W)
    ) u_gate (
        .bin(bin_idx), .start(eff_start), .span(eff_span), .in_win(in_win)
    );

    psd_group_peak #(
        .PIX_W(PIX_W), .RATIO_W(RATIO_W), .PWR_W(PWR_W)
    ) u_peak (
        .clk(clk), .rst_n(rst_n),
        .beat_valid(bin_valid), .beat_sof(bin_first), .beat_eof(bin_last),
        .in_win(in_win), .pwr(bin_pwr), .ratio(eff_ratio),
        .out_valid(px_valid), .out_pix(px_idx), .out_pwr(px_peak)
    );

    psd_pixel_locator #(
        .BIN_W(BIN_W), .PIX_W(PIX_W), .RATIO_W(RATIO_W)
    ) u_locate (
        .start(held_start), .ratio(held_ratio), .pix(pick_px), .bin(pick_bin)
    );

    // Emitted pixel indices stay inside the frame's pixel count.
    assert_pixel_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        px_valid |-> (px_idx < held_pixels));

endmodule

// File: tb/peak_span_decimator_test.sv
// Bench: sweeps start bin, ratio and pixel count over 48-bin frames and
// checks every beat against arithmetic expectations.
module peak_span_decimator_test;

    localparam int BIN_W = 12, PIX_W = 10, RATIO_W = 6, PWR_W = 16;
    localparam int NB = 48;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [BIN_W-1:0]   cfg_start_bin = '0;
    logic [RATIO_W-1:0] cfg_bins_per_px = '0;
    logic [PIX_W-1:0]   cfg_px_count = '0;
    logic bin_valid = 1'b0, bin_first = 1'b0, bin_last = 1'b0;
    logic [BIN_W-1:0] bin_idx = '0;
    logic [PWR_W-1:0] bin_pwr = '0;
    logic px_valid;
    logic [PIX_W-1:0] px_idx;
    logic [PWR_W-1:0] px_peak;
    logic [PIX_W-1:0] pick_px = '0;
    logic [BIN_W-1:0] pick_bin;

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    peak_span_decimator #(.BIN_W(BIN_W), .PIX_W(PIX_W), .RATIO_W(RATIO_W), .PWR_W(PWR_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_start_bin(cfg_start_bin), .cfg_bins_per_px(cfg_bins_per_px), .cfg_px_count(cfg_px_count),
        .bin_valid(bin_valid), .bin_first(bin_first), .bin_last(bin_last),
        .bin_idx(bin_idx), .bin_pwr(bin_pwr),
        .px_valid(px_valid), .px_idx(px_idx), .px_peak(px_peak),
        .pick_px(pick_px), .pick_bin(pick_bin)
    );

    function automatic int pw(int j, int seed);
        return (((j * 73 + seed * 29) ^ (j * 5)) % 4001) + ((j % 7 == 3) ? 4000 : 0);
    endfunction

    function automatic int grp_max(int lo, int hi, int seed);
        int m = 0;
        for (int j = lo; j <= hi; j++) if (pw(j, seed) > m) m = pw(j, seed);
        return m;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one beat at a negedge, sample results at the following negedge.
    task automatic run_frame(input int s, input int rraw, input int p, input int seed, input bit gaps);
        int r = (rraw == 0) ? 1 : rraw;
        int span = p * r;
        for (int b = 0; b < NB; b++) begin
            bit inw, ev;
            int off, ep, epw;
            string tag;
            if (b == 0) begin
                cfg_start_bin   = BIN_W'(s);
                cfg_bins_per_px = RATIO_W'(rraw);
                cfg_px_count    = PIX_W'(p);
            end
            bin_valid = 1'b1;
            bin_first = (b == 0);
            bin_last  = (b == NB - 1);
            bin_idx   = BIN_W'(b);
            bin_pwr   = PWR_W'(pw(b, seed));
            @(posedge clk);
            @(negedge clk);
            // R9: scramble the live settings after capture.
            cfg_start_bin   = BIN_W'(s + 9);
            cfg_bins_per_px = RATIO_W'(r + 2);
            cfg_px_count    = PIX_W'(p + 3);
            inw = (b >= s) && (b < s + span);
            off = b - s;
            ev = 1'b0; ep = 0; epw = 0;
            if (inw && ((off % r == r - 1) || b == NB - 1)) begin
                ev = 1'b1; ep = off / r; epw = grp_max(s + ep * r, b, seed);
            end
            if (!inw) tag = "R3";
            else if (rraw == 0) tag = "R6";
            else if (r == 1) tag = "R5";
            else if (ev && (off % r != r - 1)) tag = "R8";
            else if (ev) tag = "R2";
            else tag = "R7";
            check(px_valid == ev, {tag, " valid"}, int'(px_valid), int'(ev));
            if (ev && px_valid) begin
                check(int'(px_idx) == ep, {tag, " R4 index"}, int'(px_idx), ep);
                check(int'(px_peak) == epw, {tag, " R2 peak"}, int'(px_peak), epw);
            end
            if (gaps && (b % 5 == 4)) begin
                bin_valid = 1'b0;
                @(posedge clk);
                @(negedge clk);
                check(px_valid == 1'b0, "R11 idle", int'(px_valid), 0);
            end
        end
        bin_valid = 1'b0; bin_first = 1'b0; bin_last = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(px_valid == 1'b0, "R7 after frame", int'(px_valid), 0);
        for (int k = 0; k < 4; k++) begin
            int eb = (s + k * r) % (1 << BIN_W);
            pick_px = PIX_W'(k);
            #1;
            check(int'(pick_bin) == eb, "R10 R9 pick", int'(pick_bin), eb);
        end
    endtask

    initial begin
        int starts[3] = '{0, 5, 13};
        int counts[3] = '{2, 7, 40};
        int frame = 0;
        pick_px = PIX_W'(5);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(px_valid == 1'b0, "R1 valid", int'(px_valid), 0);
        check(int'(pick_bin) == 5, "R1 pick", int'(pick_bin), 5);
        for (int r = 0; r <= 4; r++)
            for (int si = 0; si < 3; si++)
                for (int pi = 0; pi < 3; pi++) begin
                    run_frame(starts[si], r, counts[pi], frame, frame[0]);
                    frame++;
                end
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule